// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

The block produces four independent pulse trains from one clock. Each channel owns a free-running counter, a period word, a duty word and a control word, all reached through a flat word-addressed register port with a single write strobe and combinational readback. A shared pending-flag word and a shared mask word sit after the channel blocks, and their masked OR drives one interrupt line.

Software first programs a channel's control word with the run bit clear, then loads period and duty in counts of the selected tick, and finally sets the run bit. The control word chooses the following per channel:

- whether the channel stops after one period;
- which level marks the duty phase, and which level is driven while the channel is stopped;
- whether the counter saws upward or rises and falls;
- whether the counter advances on every clock or once per prescaler tick.

Two further control bits are only stored.

Top module: `multi_pwm`

## Requirements
- R1: After the asynchronous reset, all registers read 0, every `pwm_o` bit is 0 and `irq_o` is 0.
- R2: Word address `4*ch + k` (byte address `16*ch + 4*k`) selects the counter (k=0, read-only), the period (k=1), the duty (k=2) or the control word (k=3) of channel `ch`. Byte 0x40 is the pending-flag word (bit ch per channel) and byte 0x44 is the mask word. Byte-address bits [1:0] are ignored, and any other address reads 0.
- R3: The control word keeps only bits 0 (run), 1 (repeat), 2 (capture, stored), 3 (duty level), 4 (stopped level), 5 (rise-and-fall), 8 (low-power, stored) and 9 (prescaled tick). All other bits read 0. Bits 2 and 8 do not change the output.
- R4: While the run bit is 0, the channel's output equals control bit 4 and its counter reads 0. Counter writes are dropped.
- R5: With bit 5 clear, the counter steps 0,1,…,P-1 and wraps on each tick, where P is the period. The output is at the bit-3 level while counter < duty and at the opposite level otherwise. A period of 0 or 1 gives a one-count cycle.
- R6: With bit 5 set, the counter steps 0,1,…,P,P-1,…,1 and then returns to 0, so one cycle is 2P ticks. The same counter < duty rule picks the output, which gives 2·duty−1 duty-phase ticks when 1 ≤ duty ≤ P.
- R7: A duty of 0 never produces the duty level. A duty above the highest count keeps the output at the duty level for the whole cycle.
- R8: With bit 1 clear, the run bit clears itself on the edge that ends the first cycle. The output then returns to the stopped level and the control word reads back with bit 0 clear.
- R9: Pending bit ch is set on every cycle end of channel ch, and writing 1 to it clears it. `irq_o` is the OR over channels of pending AND mask.
- R10: With bit 9 set, the counter advances only once per `PRESCALE` clocks, using a prescaler that is shared and free-running. With bit 9 clear, it advances on every clock.
- R11: The counter reads 0 in the cycle after the write that sets the run bit, and advances by one on each following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW (7) | Byte address |
| wdata_i | input | DW (32) | Write data |
| we_i | input | 1 | Write strobe, one word per cycle |
| rdata_o | output | DW (32) | Read data for `addr_i`, combinational |
| pwm_o | output | NUM_CH (4) | Channel outputs |
| irq_o | output | 1 | Masked OR of the pending flags |

## Verification
The assertions assume that software changes a channel's period only while that channel is stopped. They also assume that the run bit is the only control field changed on a running channel. Under these assumptions, a stalled counter can only come from a missing tick, and a running channel stays within the count range. The stimulus always writes the control word with the run bit clear, loads period and duty, and only then sets the run bit. Channels are stopped before they are reprogrammed, and pending flags are cleared before the interrupt mask is tested.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_REP  = 1;
  localparam int CTRL_CAP  = 2;
  localparam int CTRL_LVL  = 3;
  localparam int CTRL_IDL  = 4;
  localparam int CTRL_MID  = 5;
  localparam int CTRL_LPW  = 8;
  localparam int CTRL_PSC  = 9;

  localparam logic [31:0] CTRL_KEEP = (32'd1 << CTRL_RUN) | (32'd1 << CTRL_REP) |
                                      (32'd1 << CTRL_CAP) | (32'd1 << CTRL_LVL) |
                                      (32'd1 << CTRL_IDL) | (32'd1 << CTRL_MID) |
                                      (32'd1 << CTRL_LPW) | (32'd1 << CTRL_PSC);

  // word index within a channel block
  localparam int SLOT_CNT  = 0;
  localparam int SLOT_PER  = 1;
  localparam int SLOT_DUTY = 2;
  localparam int SLOT_CTRL = 3;
  localparam int SLOTS     = 4;

  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   div_q <= '0;
        else if (div_q == CW'(DIV-1))  div_q <= '0;
        else                           div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == CW'(DIV-1));
    end
  endgenerate
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_tick_i,
  input  logic          we_per_i,
  input  logic          we_duty_i,
  input  logic          we_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] per_o,
  output logic [DW-1:0] duty_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] cnt_o,
  output logic          run_o,
  output logic          rep_o,
  output logic          tick_o,
  output logic          eop_o,
  output logic          pwm_o
);
  logic [DW-1:0] per_q, duty_q, ctrl_q, cnt_q, cnt_nxt;
  logic [DW:0]   cnt_inc;
  dir_e          dir_q, dir_nxt;
  logic          run, rep, lvl, idl, mid, tick, eop, run_nxt;

  assign run  = ctrl_q[CTRL_RUN];
  assign rep  = ctrl_q[CTRL_REP];
  assign lvl  = ctrl_q[CTRL_LVL];
  assign idl  = ctrl_q[CTRL_IDL];
  assign mid  = ctrl_q[CTRL_MID];
  assign tick = ctrl_q[CTRL_PSC] ? slow_tick_i : 1'b1;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    eop     = 1'b0;
    if (run && tick) begin
      if (!mid) begin
        if (cnt_inc >= {1'b0, per_q}) begin
          cnt_nxt = '0;
          eop     = 1'b1;
        end else begin
          cnt_nxt = cnt_inc[DW-1:0];
        end
      end else if (dir_q == DIR_UP) begin
        if (per_q == '0) begin
          cnt_nxt = '0;
          eop     = 1'b1;
        end else if (cnt_q >= per_q) begin
          // period lowered under a running count: fall back toward 0
          if (cnt_q <= DW'(1)) begin
            cnt_nxt = '0;
            eop     = 1'b1;
          end else begin
            cnt_nxt = cnt_q - 1'b1;
            dir_nxt = DIR_DN;
          end
        end else begin
          cnt_nxt = cnt_inc[DW-1:0];
          if (cnt_inc == {1'b0, per_q}) dir_nxt = DIR_DN;
        end
      end else begin
        if (cnt_q <= DW'(1)) begin
          cnt_nxt = '0;
          dir_nxt = DIR_UP;
          eop     = 1'b1;
        end else begin
          cnt_nxt = cnt_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (we_ctrl_i)       run_nxt = wdata_i[CTRL_RUN];
    else if (eop && !rep) run_nxt = 1'b0;
    else                 run_nxt = run;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (we_per_i)  per_q  <= wdata_i;
      if (we_duty_i) duty_q <= wdata_i;
      if (we_ctrl_i)         ctrl_q <= wdata_i & DW'(CTRL_KEEP);
      else if (eop && !rep)  ctrl_q[CTRL_RUN] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (!run_nxt || !run) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_nxt;
    end
  end

  assign pwm_o  = run ? ((cnt_q < duty_q) ? lvl : ~lvl) : idl;
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign run_o  = run;
  assign rep_o  = rep;
  assign tick_o = tick;
  assign eop_o  = eop;
endmodule

// File: rtl/pwm_decode.sv
module pwm_decode
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 32,
  parameter int AW     = 7
) (
  input  logic [AW-3:0]                widx_i,
  input  logic                         we_i,
  input  logic [NUM_CH-1:0][DW-1:0]    cnt_i,
  input  logic [NUM_CH-1:0][DW-1:0]    per_i,
  input  logic [NUM_CH-1:0][DW-1:0]    duty_i,
  input  logic [NUM_CH-1:0][DW-1:0]    ctrl_i,
  input  logic [NUM_CH-1:0]            pend_i,
  input  logic [NUM_CH-1:0]            mask_i,
  output logic [NUM_CH-1:0]            we_per_o,
  output logic [NUM_CH-1:0]            we_duty_o,
  output logic [NUM_CH-1:0]            we_ctrl_o,
  output logic                         we_pend_o,
  output logic                         we_mask_o,
  output logic [DW-1:0]                rdata_o
);
  localparam int WW       = AW - 2;
  localparam int PEND_IDX = SLOTS * NUM_CH;
  localparam int MASK_IDX = PEND_IDX + 1;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_we
      assign we_per_o[c]  = we_i && (widx_i == WW'(SLOTS*c + SLOT_PER));
      assign we_duty_o[c] = we_i && (widx_i == WW'(SLOTS*c + SLOT_DUTY));
      assign we_ctrl_o[c] = we_i && (widx_i == WW'(SLOTS*c + SLOT_CTRL));
    end
  endgenerate

  assign we_pend_o = we_i && (widx_i == WW'(PEND_IDX));
  assign we_mask_o = we_i && (widx_i == WW'(MASK_IDX));

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (widx_i == WW'(SLOTS*i + SLOT_CNT))  rdata_o = cnt_i[i];
      if (widx_i == WW'(SLOTS*i + SLOT_PER))  rdata_o = per_i[i];
      if (widx_i == WW'(SLOTS*i + SLOT_DUTY)) rdata_o = duty_i[i];
      if (widx_i == WW'(SLOTS*i + SLOT_CTRL)) rdata_o = ctrl_i[i];
    end
    if (widx_i == WW'(PEND_IDX)) rdata_o[NUM_CH-1:0] = pend_i;
    if (widx_i == WW'(MASK_IDX)) rdata_o[NUM_CH-1:0] = mask_i;
  end
endmodule

// File: rtl/multi_pwm.sv
module multi_pwm
  import pwm_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DW       = 32,
  parameter int PRESCALE = 4,
  parameter int AW       = $clog2((SLOTS*NUM_CH + 2) * 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0][DW-1:0] cnt_a, per_a, duty_a, ctrl_a;
  logic [NUM_CH-1:0] we_per, we_duty, we_ctrl;
  logic [NUM_CH-1:0] run_v, rep_v, tick_v, eop_v;
  logic [NUM_CH-1:0] pend_q, mask_q;
  logic              we_pend, we_mask, slow_tick;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^addr_i[1:0];

  pwm_prescale #(.DIV(PRESCALE)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (slow_tick)
  );

  pwm_decode #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_dec (
    .widx_i    (addr_i[AW-1:2]),
    .we_i      (we_i),
    .cnt_i     (cnt_a),
    .per_i     (per_a),
    .duty_i    (duty_a),
    .ctrl_i    (ctrl_a),
    .pend_i    (pend_q),
    .mask_i    (mask_q),
    .we_per_o  (we_per),
    .we_duty_o (we_duty),
    .we_ctrl_o (we_ctrl),
    .we_pend_o (we_pend),
    .we_mask_o (we_mask),
    .rdata_o   (rdata_o)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_chan #(.DW(DW)) u_ch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .slow_tick_i (slow_tick),
        .we_per_i    (we_per[c]),
        .we_duty_i   (we_duty[c]),
        .we_ctrl_i   (we_ctrl[c]),
        .wdata_i     (wdata_i),
        .per_o       (per_a[c]),
        .duty_o      (duty_a[c]),
        .ctrl_o      (ctrl_a[c]),
        .cnt_o       (cnt_a[c]),
        .run_o       (run_v[c]),
        .rep_o       (rep_v[c]),
        .tick_o      (tick_v[c]),
        .eop_o       (eop_v[c]),
        .pwm_o       (pwm_o[c])
      );
    end
  endgenerate

  // a fresh cycle end wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~(we_pend ? wdata_i[NUM_CH-1:0] : '0)) | eop_v;
      if (we_mask) mask_q <= wdata_i[NUM_CH-1:0];
    end
  end

  assign irq_o = |(pend_q & mask_q);
endmodule

// File: rtl/pwm_chk.sv
module pwm_chk #(
  parameter int NUM_CH = 4,
  parameter int DW     = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_CH-1:0]         run_v,
  input logic [NUM_CH-1:0]         rep_v,
  input logic [NUM_CH-1:0]         tick_v,
  input logic [NUM_CH-1:0]         eop_v,
  input logic [NUM_CH-1:0]         we_ctrl,
  input logic [NUM_CH-1:0]         pend_q,
  input logic [NUM_CH-1:0][DW-1:0] cnt_a
);
  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_a
      assert_cnt_clear_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_v[c] |-> (cnt_a[c] == '0));

      assert_eop_only_running_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eop_v[c] |-> run_v[c]);

      assert_oneshot_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eop_v[c] && !rep_v[c] && !we_ctrl[c]) |=> !run_v[c]);

      assert_pend_on_eop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eop_v[c] |=> pend_q[c]);

      assert_hold_without_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_v[c] && !tick_v[c] && !we_ctrl[c]) |=> $stable(cnt_a[c]));
    end
  endgenerate
endmodule

bind multi_pwm pwm_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_v   (run_v),
  .rep_v   (rep_v),
  .tick_v  (tick_v),
  .eop_v   (eop_v),
  .we_ctrl (we_ctrl),
  .pend_q  (pend_q),
  .cnt_a   (cnt_a)
);

// File: tb/tb_multi_pwm.sv
module tb_multi_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int PSC        = 4;

  typedef struct {
    int    ch;
    logic  val;
    string req;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  sb_item_t sb_q[$];

  multi_pwm #(.NUM_CH(4), .DW(32), .PRESCALE(PSC)) dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .wdata_i (wdata),
    .we_i    (we),
    .rdata_o (rdata),
    .pwm_o   (pwm),
    .irq_o   (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops one expected output bit per cycle, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(pwm[it.ch] == it.val, it.req, {31'd0, pwm[it.ch]}, {31'd0, it.val});
      end
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_now(logic [6:0] a, logic [31:0] exp, string req);
    addr = a;
    #1;
    check(rdata == exp, req, rdata, exp);
  endtask

  task automatic rd(logic [6:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    rd_now(a, exp, req);
  endtask

  function automatic logic model_lvl(int k, int per, int duty, bit mid, bit lvl);
    int c, m, p;
    p = (per < 1) ? 1 : per;
    if (!mid) c = k % p;
    else begin
      m = k % (2*p);
      c = (m <= p) ? m : 2*p - m;
    end
    return (c < duty) ? lvl : !lvl;
  endfunction

  task automatic run_wave(int ch, int per, int duty, logic [31:0] ctrl, int n, string req);
    logic [6:0] base;
    base = 7'(16*ch);
    wr(base + 7'd12, ctrl & ~32'd1);
    wr(base + 7'd4, per);
    wr(base + 7'd8, duty);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      sb_item_t it;
      it.ch  = ch;
      it.req = req;
      if (!ctrl[1] && k >= per) it.val = ctrl[4];
      else it.val = model_lvl(k, per, duty, ctrl[5], ctrl[3]);
      sb_q.push_back(it);
    end
    addr = base + 7'd12; wdata = ctrl | 32'd1; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lo, hi, guard;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(pwm == 4'b0, "R1 pwm", {28'd0, pwm}, 32'd0);
    check(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    rd(7'h0C, 32'd0, "R1 ctrl0");
    rd(7'h34, 32'd0, "R1 per3");
    rd(7'h40, 32'd0, "R1 pend");

    // R2 map and readback
    wr(7'h24, 32'h0000_1234);
    rd(7'h24, 32'h0000_1234, "R2 per2");
    rd(7'h26, 32'h0000_1234, "R2 lsb ignored");
    wr(7'h38, 32'd7);
    rd(7'h38, 32'd7, "R2 duty3");
    rd(7'h48, 32'd0, "R2 unmapped");
    wr(7'h44, 32'h0000_0005);
    rd(7'h44, 32'h0000_0005, "R2 mask");
    wr(7'h44, 32'd0);

    // R4 counter write dropped while stopped
    wr(7'h00, 32'd5);
    rd(7'h00, 32'd0, "R4 cnt ro");

    // R3 control masking, R4 stopped level
    wr(7'h1C, 32'hFFFF_FFFE);
    rd(7'h1C, 32'h0000_033E, "R3 ctrl keep");
    check(pwm[1] == 1'b1, "R4 idle high", {31'd0, pwm[1]}, 32'd1);
    wr(7'h1C, 32'h0000_0104);
    rd(7'h1C, 32'h0000_0104, "R3 stored bits");
    check(pwm[1] == 1'b0, "R4 idle low", {31'd0, pwm[1]}, 32'd0);

    // R5 sawtooth, bits 2 and 8 set to show no effect (R3)
    run_wave(0, 10, 3, 32'h0000_010E, 20, "R5 left ch0 / R3");
    rd(7'h0C, 32'h0000_010F, "R5 ctrl running");
    wr(7'h0C, 32'h0000_010E);

    // R5 inverted duty level, R4 stopped high
    wr(7'h1C, 32'h0000_0012);
    @(negedge clk);
    check(pwm[1] == 1'b1, "R4 idle before run", {31'd0, pwm[1]}, 32'd1);
    run_wave(1, 6, 2, 32'h0000_0012, 12, "R5 low-active ch1");
    wr(7'h1C, 32'h0000_0012);
    check(pwm[1] == 1'b1, "R4 idle after stop", {31'd0, pwm[1]}, 32'd1);

    // R6 rise-and-fall
    run_wave(2, 4, 2, 32'h0000_002A, 16, "R6 mid ch2");
    wr(7'h2C, 32'h0000_002A);
    run_wave(2, 3, 3, 32'h0000_002A, 12, "R6 mid full duty");
    wr(7'h2C, 32'h0000_002A);

    // R7 duty extremes
    run_wave(0, 5, 0, 32'h0000_000A, 10, "R7 duty zero");
    wr(7'h0C, 32'h0000_000A);
    run_wave(0, 5, 7, 32'h0000_000A, 10, "R7 duty over");
    wr(7'h0C, 32'h0000_000A);

    // R8 single cycle
    run_wave(3, 5, 2, 32'h0000_0008, 10, "R8 one-shot ch3");
    rd(7'h3C, 32'h0000_0008, "R8 run cleared");
    rd(7'h30, 32'd0, "R8 cnt cleared");

    // R9 pending and mask
    wr(7'h40, 32'h0000_000F);
    rd(7'h40, 32'd0, "R9 pend cleared");
    check(irq == 1'b0, "R9 irq low", {31'd0, irq}, 32'd0);
    wr(7'h44, 32'h0000_0008);
    wr(7'h3C, 32'h0000_0009);
    repeat (8) @(negedge clk);
    rd(7'h40, 32'h0000_0008, "R9 pend set");
    check(irq == 1'b1, "R9 irq set", {31'd0, irq}, 32'd1);
    wr(7'h44, 32'h0000_0007);
    check(irq == 1'b0, "R9 irq masked", {31'd0, irq}, 32'd0);
    wr(7'h44, 32'h0000_0008);
    check(irq == 1'b1, "R9 irq unmasked", {31'd0, irq}, 32'd1);
    wr(7'h40, 32'h0000_0008);
    check(irq == 1'b0, "R9 irq after clear", {31'd0, irq}, 32'd0);
    rd(7'h40, 32'd0, "R9 pend after clear");

    // R10 prescaled tick: P=3, D=1 -> 4 clocks high, 8 low
    wr(7'h04, 32'd3);
    wr(7'h08, 32'd1);
    wr(7'h0C, 32'h0000_020B);
    guard = 0;
    while (pwm[0] != 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    while (pwm[0] != 1'b0 && guard < 100) begin @(negedge clk); guard++; end
    lo = 0;
    while (pwm[0] == 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    hi = 0;
    while (pwm[0] == 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    check(lo == 2*PSC, "R10 low span", lo, 2*PSC);
    check(hi == PSC, "R10 high span", hi, PSC);
    wr(7'h0C, 32'h0000_020A);

    // R11 counter start
    wr(7'h14, 32'd100);
    wr(7'h18, 32'd50);
    wr(7'h1C, 32'h0000_000B);
    rd_now(7'h10, 32'd0, "R11 cnt start");
    @(negedge clk);
    rd_now(7'h10, 32'd1, "R11 cnt step");
    repeat (3) @(negedge clk);
    rd_now(7'h10, 32'd4, "R11 cnt later");
    wr(7'h1C, 32'h0000_000A);
    rd(7'h10, 32'd0, "R4 cnt after stop");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule